// File: doc/BRIEF.md
# DRAM Range Router with Node Interleave

This block steers a 40-bit physical memory request to the node that owns it. Software programs eight range pairs. Each pair holds an inclusive window over address bits 39..24, separate read and write permissions, a destination node number and optional node interleave. With interleave, several pairs can cover the same window. Each pair then claims only the addresses whose selected bits among A[14:12] equal that pair's select value.

A lookup presents an address and a read/write flag for one cycle. One clock edge later the block returns a registered response: a hit flag, the winning node and a no-match flag. When more than one pair claims an address, the lowest-numbered pair wins. A register port writes the pairs and reads them back combinationally, so software can confirm what was stored.

Top module: `drr_range_router`

## Requirements
- R1: After reset, every register reads zero, so all read and write enables are clear. rsp_valid, rsp_hit and rsp_miss are low and rsp_node is 0.
- R2: Pair i has its base register at byte offset 8*i and its limit register at 8*i+4. cfg_addr[1:0] are ignored.
  - Base register fields: bit 0 read enable, bit 1 write enable, [10:8] interleave code, [31:16] range start A[39:24].
  - Limit register fields: [2:0] node, [10:8] interleave select, [31:16] range end A[39:24].
  - All other bits are stored as zero and read back as zero.
- R3: A written interleave code of 010, 100, 101 or 110 is stored as 000 (no interleave).
- R4: A pair can match only when base[31:16] <= A[39:24] <= limit[31:16]. Both bounds are inclusive.
- R5: A read lookup (lk_write=0) needs the pair's read enable set. A write lookup (lk_write=1) needs its write enable set.
- R6: Each interleave code selects which of A[14:12] take part in the match: 000 uses none, 001 uses A[12], 011 uses A[12] and A[14], 111 uses all three. Every bit that takes part must equal the bit in the same position of the select field, where select bit 0 compares A[12], bit 1 compares A[13] and bit 2 compares A[14].
- R7: When several pairs match, rsp_node is the node of the lowest-numbered matching pair.
- R8: When no pair matches, rsp_miss=1, rsp_hit=0 and rsp_node=0. When a pair matches, rsp_hit=1 and rsp_miss=0.
- R9: rsp_valid is high exactly one cycle after a cycle with lk_valid high. rsp_hit, rsp_miss and rsp_node keep their values across cycles without a lookup.
- R10: A lookup in the same cycle as a register write is decoded against the configuration that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NUM_PAIRS)+3 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 40 | Physical address to decode |
| lk_write | input | 1 | 1 for a write request, 0 for a read |
| rsp_valid | output | 1 | Response valid, one cycle after lk_valid |
| rsp_hit | output | 1 | A pair matched |
| rsp_node | output | 3 | Destination node of the winning pair |
| rsp_miss | output | 1 | No pair matched |

## Verification
A register write and a lookup can land on the same clock edge. The risk is that a freshly written enable or window leaks into the response being captured at that edge. The bench provokes this by presenting a write lookup into a write-enabled pair while the same cycle clears that pair's base register. It expects a hit on the old node. The next lookup to the same address must then miss, which shows that the write did take effect one cycle later.

// File: rtl/drr_pkg.sv
package drr_pkg;

  localparam int PA_W        = 40;
  localparam int RANGE_LSB   = 24;
  localparam int RANGE_W     = PA_W - RANGE_LSB;
  localparam int NODE_W      = 3;
  localparam int ILV_W       = 3;
  localparam int ILV_LSB     = 12;
  localparam int REG_W       = 32;

  // field positions inside the programmed registers
  localparam int F_RDEN      = 0;
  localparam int F_WREN      = 1;
  localparam int F_NODE_LSB  = 0;
  localparam int F_ILV_LSB   = 8;
  localparam int F_RANGE_LSB = 16;

  typedef struct packed {
    logic                 rd_en;
    logic                 wr_en;
    logic [ILV_W-1:0]     ilv_code;
    logic [RANGE_W-1:0]   base_hi;
    logic [NODE_W-1:0]    node;
    logic [ILV_W-1:0]     ilv_sel;
    logic [RANGE_W-1:0]   limit_hi;
  } pair_cfg_t;

  // reserved interleave codes collapse to "no interleave"
  function automatic logic [ILV_W-1:0] legal_ilv(input logic [ILV_W-1:0] code);
    case (code)
      3'b000, 3'b001, 3'b011, 3'b111: return code;
      default:                        return '0;
    endcase
  endfunction

  // mask over A[14:12] (bit0 = A12) taking part in the node compare
  function automatic logic [ILV_W-1:0] ilv_mask(input logic [ILV_W-1:0] code);
    case (code)
      3'b001:  return 3'b001;
      3'b011:  return 3'b101;
      3'b111:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/drr_regfile.sv
module drr_regfile
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int AW        = $clog2(NUM_PAIRS) + 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [AW-1:0]                      cfg_addr,
  input  logic [REG_W-1:0]                   cfg_wdata,
  output logic [REG_W-1:0]                   cfg_rdata,
  output pair_cfg_t [NUM_PAIRS-1:0]          pair_cfg
);

  localparam int IDX_W = AW - 3;

  logic [IDX_W-1:0] slot;
  logic             sel_limit;
  logic [1:0]       unused_byte_lsb;

  assign slot            = cfg_addr[AW-1:3];
  assign sel_limit       = cfg_addr[2];
  assign unused_byte_lsb = cfg_addr[1:0];

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic      base_wr;
    logic      limit_wr;
    pair_cfg_t cfg_d;
    pair_cfg_t cfg_q;

    assign base_wr  = cfg_we && (slot == IDX_W'(g)) && !sel_limit;
    assign limit_wr = cfg_we && (slot == IDX_W'(g)) &&  sel_limit;

    always_comb begin
      cfg_d = cfg_q;
      if (base_wr) begin
        cfg_d.rd_en    = cfg_wdata[F_RDEN];
        cfg_d.wr_en    = cfg_wdata[F_WREN];
        cfg_d.ilv_code = legal_ilv(cfg_wdata[F_ILV_LSB +: ILV_W]);
        cfg_d.base_hi  = cfg_wdata[F_RANGE_LSB +: RANGE_W];
      end
      if (limit_wr) begin
        cfg_d.node     = cfg_wdata[F_NODE_LSB +: NODE_W];
        cfg_d.ilv_sel  = cfg_wdata[F_ILV_LSB +: ILV_W];
        cfg_d.limit_hi = cfg_wdata[F_RANGE_LSB +: RANGE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (base_wr || limit_wr) begin
        cfg_q <= cfg_d;
      end
    end

    assign pair_cfg[g] = cfg_q;
  end

  // readback: reserved positions stay zero
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (slot == IDX_W'(i)) begin
        if (sel_limit) begin
          cfg_rdata[F_NODE_LSB  +: NODE_W]  = pair_cfg[i].node;
          cfg_rdata[F_ILV_LSB   +: ILV_W]   = pair_cfg[i].ilv_sel;
          cfg_rdata[F_RANGE_LSB +: RANGE_W] = pair_cfg[i].limit_hi;
        end else begin
          cfg_rdata[F_RDEN]                 = pair_cfg[i].rd_en;
          cfg_rdata[F_WREN]                 = pair_cfg[i].wr_en;
          cfg_rdata[F_ILV_LSB   +: ILV_W]   = pair_cfg[i].ilv_code;
          cfg_rdata[F_RANGE_LSB +: RANGE_W] = pair_cfg[i].base_hi;
        end
      end
    end
  end

endmodule

// File: rtl/drr_pair_match.sv
module drr_pair_match
  import drr_pkg::*;
(
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ILV_W-1:0]   ilv_code,
  input  logic [ILV_W-1:0]   ilv_sel,
  input  logic [RANGE_W-1:0] base_hi,
  input  logic [RANGE_W-1:0] limit_hi,
  input  logic [RANGE_W-1:0] req_hi,
  input  logic [ILV_W-1:0]   req_ilv,
  input  logic               req_write,
  output logic               match
);

  logic             in_window;
  logic             permitted;
  logic             ilv_ok;
  logic [ILV_W-1:0] cmp_mask;

  assign in_window = (req_hi >= base_hi) && (req_hi <= limit_hi);
  assign permitted = req_write ? wr_en : rd_en;
  assign cmp_mask  = ilv_mask(ilv_code);
  assign ilv_ok    = ((req_ilv ^ ilv_sel) & cmp_mask) == '0;
  assign match     = in_window && permitted && ilv_ok;

endmodule

// File: rtl/drr_resp.sv
module drr_resp
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                lk_valid,
  input  logic [NUM_PAIRS-1:0]                match_vec,
  input  logic [NUM_PAIRS-1:0][NODE_W-1:0]    node_vec,
  output logic                                rsp_valid,
  output logic                                rsp_hit,
  output logic [NODE_W-1:0]                   rsp_node,
  output logic                                rsp_miss
);

  logic              any_d;
  logic [NODE_W-1:0] node_d;

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    any_d  = 1'b0;
    node_d = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_d  = 1'b1;
        node_d = node_vec[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
      rsp_node <= '0;
    end else if (lk_valid) begin
      rsp_hit  <= any_d;
      rsp_miss <= !any_d;
      rsp_node <= node_d;
    end
  end

endmodule

// File: rtl/drr_range_router.sv
module drr_range_router
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  localparam int AW       = $clog2(NUM_PAIRS) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lk_valid,
  input  logic [PA_W-1:0]   lk_addr,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NODE_W-1:0] rsp_node,
  output logic              rsp_miss
);

  pair_cfg_t [NUM_PAIRS-1:0]         pair_cfg;
  logic [NUM_PAIRS-1:0]              match_vec;
  logic [NUM_PAIRS-1:0][NODE_W-1:0]  node_vec;
  logic [RANGE_W-1:0]                req_hi;
  logic [ILV_W-1:0]                  req_ilv;
  logic [PA_W-RANGE_W-ILV_W-1:0]     unused_addr_bits;

  assign req_hi           = lk_addr[RANGE_LSB +: RANGE_W];
  assign req_ilv          = lk_addr[ILV_LSB +: ILV_W];
  assign unused_addr_bits = {lk_addr[RANGE_LSB-1:ILV_LSB+ILV_W], lk_addr[ILV_LSB-1:0]};

  drr_regfile #(.NUM_PAIRS(NUM_PAIRS), .AW(AW)) i_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pair_cfg  (pair_cfg)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_match
    drr_pair_match i_match (
      .rd_en     (pair_cfg[g].rd_en),
      .wr_en     (pair_cfg[g].wr_en),
      .ilv_code  (pair_cfg[g].ilv_code),
      .ilv_sel   (pair_cfg[g].ilv_sel),
      .base_hi   (pair_cfg[g].base_hi),
      .limit_hi  (pair_cfg[g].limit_hi),
      .req_hi    (req_hi),
      .req_ilv   (req_ilv),
      .req_write (lk_write),
      .match     (match_vec[g])
    );
    assign node_vec[g] = pair_cfg[g].node;
  end

  drr_resp #(.NUM_PAIRS(NUM_PAIRS)) i_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .match_vec (match_vec),
    .node_vec  (node_vec),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_node  (rsp_node),
    .rsp_miss  (rsp_miss)
  );

endmodule

// File: rtl/drr_checker.sv
module drr_checker
  import drr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  localparam int AW       = $clog2(NUM_PAIRS) + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     cfg_addr,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              lk_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NODE_W-1:0] rsp_node,
  input logic              rsp_miss
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);                                             // R9
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);                                           // R9
  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(rsp_hit) && $stable(rsp_miss) && $stable(rsp_node))); // R9
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));                         // R8
  AST_MISS_NODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_node == '0));                                      // R8
  AST_BASE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr[2] |-> ((cfg_rdata & 32'h0000_F8FC) == '0));               // R2
  AST_LIMIT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr[2] |-> ((cfg_rdata & 32'h0000_F8F8) == '0));                // R2
  AST_ILV_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr[2] |-> (cfg_rdata[10:8] inside {3'b000, 3'b001, 3'b011, 3'b111})); // R3

endmodule

bind drr_range_router drr_checker #(.NUM_PAIRS(NUM_PAIRS)) i_drr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .lk_valid  (lk_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_node  (rsp_node),
  .rsp_miss  (rsp_miss)
);

// File: tb/test_drr_range_router.sv
module test_drr_range_router;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 8;
  localparam int AW         = $clog2(NP) + 3;
  localparam int WATCHDOG   = 150000;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          lk_valid;
  logic [39:0]   lk_addr;
  logic          lk_write;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [2:0]    rsp_node;
  logic          rsp_miss;

  int n_checks = 0;
  int n_bad    = 0;
  logic [31:0] m_base  [NP];
  logic [31:0] m_limit [NP];

  drr_range_router #(.NUM_PAIRS(NP)) i_drr_range_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_write(lk_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_miss(rsp_miss)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [2:0] c);
    return (c == 3'b000 || c == 3'b001 || c == 3'b011 || c == 3'b111) ? c : 3'b000;
  endfunction

  function automatic logic [2:0] exp_mask(input logic [2:0] c);
    case (c)
      3'b001:  return 3'b001;
      3'b011:  return 3'b101;
      3'b111:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // expected {hit, node} from the programmed images
  function automatic logic [3:0] model(input logic [39:0] a, input logic w);
    for (int i = 0; i < NP; i++) begin
      logic en, inr, ok;
      en  = w ? m_base[i][1] : m_base[i][0];
      inr = (a[39:24] >= m_base[i][31:16]) && (a[39:24] <= m_limit[i][31:16]);
      ok  = ((a[14:12] ^ m_limit[i][10:8]) & exp_mask(m_base[i][10:8])) == 3'b000;
      if (en && inr && ok) return {1'b1, m_limit[i][2:0]};
    end
    return 4'b0000;
  endfunction

  task automatic cfg_wr(input int idx, input logic lim, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(idx*8 + (lim ? 4 : 0)); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (lim) m_limit[idx] = d & 32'hFFFF_0707;
    else     m_base[idx]  = (d & 32'hFFFF_0003) | {21'b0, exp_code(d[10:8]), 8'b0};
  endtask

  task automatic cfg_rd_chk(input int idx, input logic lim, input string tag);
    cfg_addr = AW'(idx*8 + (lim ? 4 : 0) + 2);   // low byte bits must be ignored
    #1;
    chk(tag, cfg_rdata, lim ? m_limit[idx] : m_base[idx]);
  endtask

  task automatic lookup(input logic [39:0] a, input logic w, input string tag);
    logic [3:0] e;
    e = model(a, w);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_write = w;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(tag, {26'b0, rsp_valid, rsp_hit, rsp_miss, rsp_node},
        {26'b0, 1'b1, e[3], !e[3], e[2:0]});
  endtask

  function automatic logic [39:0] mk(input logic [15:0] hi, input logic [2:0] il);
    return {hi, 9'h1A5, il, 12'hABC};
  endfunction

  task automatic sweep(input string tag);
    logic [15:0] extra [8] = '{16'h00FF, 16'h0100, 16'h0101, 16'h0102,
                               16'h01FF, 16'h0200, 16'h0201, 16'hFFFF};
    for (int h = 0; h < 16'h60 + 8; h++) begin
      logic [15:0] hv;
      hv = (h < 16'h60) ? 16'(h) : extra[h - 16'h60];
      for (int il = 0; il < 8; il++) begin
        for (int w = 0; w < 2; w++) begin
          lookup(mk(hv, 3'(il)), 1'(w), tag);
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin m_base[i] = '0; m_limit[i] = '0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0; lk_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {28'b0, rsp_valid, rsp_hit, rsp_miss, 1'b0}, 32'h0);
    chk("R1 node", {29'b0, rsp_node}, 32'h0);
    for (int i = 0; i < NP; i++) begin
      cfg_rd_chk(i, 1'b0, "R1 base zero");
      cfg_rd_chk(i, 1'b1, "R1 limit zero");
    end
    lookup(mk(16'h0000, 3'b000), 1'b0, "R1 empty table miss");

    // R2 field placement and reserved bits
    for (int i = 0; i < NP; i++) begin
      cfg_wr(i, 1'b1, 32'hFFFF_FFFF);
      cfg_wr(i, 1'b0, 32'hFFFF_FFFF);
      cfg_rd_chk(i, 1'b0, "R2 base fields");
      cfg_rd_chk(i, 1'b1, "R2 limit fields");
    end
    chk("R2 base image", m_base[3], 32'hFFFF_0703);
    // R3 every interleave code
    for (int c = 0; c < 8; c++) begin
      cfg_wr(0, 1'b0, 32'h1234_0000 | (32'(c) << 8) | 32'h1);
      cfg_rd_chk(0, 1'b0, "R3 code stored");
    end
    for (int i = 0; i < NP; i++) begin
      cfg_wr(i, 1'b1, 32'h0); cfg_wr(i, 1'b0, 32'h0);
    end

    // working map: limit before base
    cfg_wr(0, 1'b1, 32'h001F_0005); cfg_wr(0, 1'b0, 32'h0010_0003);
    cfg_wr(1, 1'b1, 32'h0030_0002); cfg_wr(1, 1'b0, 32'h0018_0201); // reserved code 010
    cfg_wr(2, 1'b1, 32'h004F_0003); cfg_wr(2, 1'b0, 32'h0040_0002);
    cfg_wr(3, 1'b1, 32'h0101_0004); cfg_wr(3, 1'b0, 32'h0100_0303);
    cfg_wr(4, 1'b1, 32'h0101_0105); cfg_wr(4, 1'b0, 32'h0100_0303);
    cfg_wr(5, 1'b1, 32'h0101_0406); cfg_wr(5, 1'b0, 32'h0100_0303);
    cfg_wr(6, 1'b1, 32'h0101_0507); cfg_wr(6, 1'b0, 32'h0100_0303);
    cfg_wr(7, 1'b1, 32'h0201_0101); cfg_wr(7, 1'b0, 32'h0200_0103);
    cfg_rd_chk(1, 1'b0, "R3 reserved code reads 000");

    // directed points
    lookup(mk(16'h0010, 3'b000), 1'b0, "R4 lower bound inclusive");
    chk("R4 lower node", {29'b0, rsp_node}, 32'd5);
    lookup(mk(16'h0030, 3'b000), 1'b0, "R4 upper bound inclusive");
    chk("R4 upper node", {29'b0, rsp_node}, 32'd2);
    lookup(mk(16'h0040, 3'b000), 1'b0, "R5 read to write-only pair misses");
    chk("R5 miss flag", {31'b0, rsp_miss}, 32'd1);
    lookup(mk(16'h0040, 3'b000), 1'b1, "R5 write to write-only pair hits");
    chk("R5 node", {29'b0, rsp_node}, 32'd3);
    lookup(mk(16'h0020, 3'b000), 1'b1, "R5 write to read-only pair misses");
    lookup(mk(16'h0018, 3'b000), 1'b0, "R7 overlap lowest pair");
    chk("R7 node", {29'b0, rsp_node}, 32'd5);
    lookup(mk(16'h0100, 3'b100), 1'b0, "R6 four-way select A14");
    chk("R6 node", {29'b0, rsp_node}, 32'd6);
    lookup(mk(16'h0100, 3'b010), 1'b0, "R6 A13 ignored in four-way");
    chk("R6 A13 node", {29'b0, rsp_node}, 32'd4);
    lookup(mk(16'h0200, 3'b000), 1'b0, "R6 two-way other half misses");
    lookup(mk(16'h0300, 3'b000), 1'b0, "R8 no match");
    chk("R8 node zero", {29'b0, rsp_node}, 32'd0);

    // R9 hold across idle cycles
    lookup(mk(16'h0101, 3'b101), 1'b0, "R9 lookup");
    @(negedge clk); @(negedge clk);
    chk("R9 idle hold", {28'b0, rsp_valid, rsp_hit, rsp_miss, 1'b0}, 32'b0100);
    chk("R9 idle node", {29'b0, rsp_node}, 32'd7);

    sweep("R4 sweep four-way");
    cfg_wr(3, 1'b0, 32'h0100_0703);
    sweep("R6 sweep eight-way");

    // R10 write and lookup on the same edge
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(16'h0045, 3'b000); lk_write = 1'b1;
    cfg_we = 1'b1; cfg_addr = AW'(2*8); cfg_wdata = 32'h0;
    @(negedge clk);
    lk_valid = 1'b0; cfg_we = 1'b0;
    m_base[2] = 32'h0;
    chk("R10 old config used", {28'b0, rsp_valid, rsp_hit, rsp_miss, 1'b0}, 32'b1100);
    chk("R10 old node", {29'b0, rsp_node}, 32'd3);
    lookup(mk(16'h0045, 3'b000), 1'b1, "R10 new config next lookup");

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule